// File: doc/BRIEF.md
# Quadrature NCO Down-Mixer

This block moves a real, signed intermediate-frequency sample stream to complex baseband. A 32-bit phase accumulator drives a sine/cosine lookup built from one quarter-wave table. Each incoming sample is multiplied by the cosine value to form the in-phase (I) output and by the sine value to form the quadrature (Q) output. Both full-width products are then rounded and saturated to a narrower output word, so that the decimation filters downstream start from a bounded width.

The oscillator runs on every clock, whether or not the input sample is valid. Its tuning word comes out of reset set so that a 100 MHz clock yields a 21.4 MHz tone, and a write strobe can replace it at any time. The I and Q paths share one pipeline, so a sample and its valid flag come out together a fixed number of clocks after they go in.

Top module: `iq_downmix`

## Requirements
- R1: While rst_ni is low, valid_o, i_o and q_o are all zero. The phase accumulator is cleared, so the first sample taken after reset is mixed at phase index 0.
- R2: The 32-bit phase accumulator adds the tuning word on every clock and wraps modulo 2^32. Its top 10 bits form the phase index p. After reset the tuning word is 919123001, which is round(0.214 × 2^32).
- R3: For phase index p, the sine value is round(8191 × sin(2π(p+0.5)/1024)) with ties rounded away from zero. The cosine value is the sine value at index (p+256) mod 1024. Both values are 14-bit signed.
- R4: i_o is derived from sample × cosine and q_o from sample × sine. The sample and the phase are both taken at the same clock edge, and the two paths have the same latency.
- R5: Each 28-bit product P is rounded half-up to floor(P/1024 + 0.5).
- R6: A rounded value above 32767 is output as 32767, and one below −32768 is output as −32768.
- R7: valid_o equals valid_i as sampled three clock edges earlier. The I/Q data for a sample taken at edge k can be read after edge k+2.
- R8: When inc_we_i is high at a clock edge, inc_i becomes the tuning word. The accumulator step taken at that same edge still uses the old word.
- R9: The phase advances on every clock, including clocks where valid_i is low. A gap in the input stream therefore does not shift the oscillator's phase relative to time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample qualifier |
| sample_i | input | 14 | Signed IF sample |
| inc_we_i | input | 1 | Tuning-word load strobe |
| inc_i | input | 32 | New tuning word |
| valid_o | output | 1 | Output qualifier |
| i_o | output | 16 | Signed in-phase output |
| q_o | output | 16 | Signed quadrature output |

## Verification
The bench keeps a running phase model and compares every output word against it. A design that pairs a sample with the wrong phase, swaps sine and cosine, or uses a different latency on one path therefore fails on the first tone it sees. Full-scale positive and negative inputs drive the products past the output range, which exposes a missing saturation clamp or a design that truncates instead of rounding. Tuning-word writes are placed at chosen edges, and the input valid is gapped, to catch a new word applied one step early and an oscillator that stalls while valid is low. A reset in the middle of a run must bring the phase back to index 0.

// File: rtl/iq_downmix_pkg.sv
package iq_downmix_pkg;
  localparam int unsigned PHASE_W   = 32;
  localparam int unsigned IDX_W     = 10;
  localparam int unsigned SAMPLE_W  = 14;
  localparam int unsigned OUT_W     = 16;
  localparam int unsigned ROUND_SH  = 10;
  localparam logic [PHASE_W-1:0] DEF_INC = 32'd919123001;
endpackage

// File: rtl/nco_phase.sv
module nco_phase #(
  parameter int unsigned PW = 32,
  parameter int unsigned IW = 10,
  parameter logic [PW-1:0] INIT_INC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] inc_i,
  output logic [IW-1:0] idx_o
);
  logic [PW-1:0] acc_q, inc_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      inc_q  <= INIT_INC;
      seen_q <= 1'b0;
    end else begin
      acc_q  <= acc_q + inc_q;
      seen_q <= 1'b1;
      if (we_i) inc_q <= inc_i;
    end
  end

  assign idx_o = acc_q[PW-1 -: IW];

  p_phase_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (acc_q == $past(acc_q) + $past(inc_q)));
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int unsigned IW = 10,
  parameter int unsigned DW = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IW-1:0]        idx_i,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o
);
  localparam int unsigned AW   = IW - 2;
  localparam int unsigned QN   = 1 << AW;
  localparam int unsigned MW   = DW - 1;
  localparam real         AMPR = real'((1 << (DW - 1)) - 1);
  localparam real         PI   = 3.14159265358979323846;

  logic [MW-1:0] qtab [QN];

  for (genvar k = 0; k < QN; k++) begin : g_tab
    localparam real ANG = PI * (real'(k) + 0.5) / (2.0 * real'(QN));
    localparam int  VAL = int'($floor(AMPR * $sin(ANG) + 0.5));
    assign qtab[k] = MW'(VAL);
  end

  logic [IW-1:0]        cidx;
  logic [AW-1:0]        s_addr, c_addr;
  logic signed [DW-1:0] s_mag, c_mag, s_val, c_val;

  assign cidx   = idx_i + IW'(QN);
  // odd quadrants read the table mirrored, upper half is negated
  assign s_addr = idx_i[IW-2] ? ~idx_i[AW-1:0] : idx_i[AW-1:0];
  assign c_addr = cidx[IW-2]  ? ~cidx[AW-1:0]  : cidx[AW-1:0];
  assign s_mag  = {1'b0, qtab[s_addr]};
  assign c_mag  = {1'b0, qtab[c_addr]};
  assign s_val  = idx_i[IW-1] ? -s_mag : s_mag;
  assign c_val  = cidx[IW-1]  ? -c_mag : c_mag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= s_val;
      cos_o <= c_val;
    end
  end

  p_quad0_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i[IW-1 -: 2] == 2'b00) |=> (sin_o > 0 && cos_o > 0));
endmodule

// File: rtl/mix_round.sv
module mix_round #(
  parameter int unsigned PW = 28,
  parameter int unsigned OW = 16,
  parameter int unsigned SH = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [PW-1:0] p_i,
  output logic signed [OW-1:0] r_o
);
  localparam int unsigned SW = PW + 1;
  localparam longint MAXV  = (longint'(1) << (OW - 1)) - 1;
  localparam longint MINV  = -(longint'(1) << (OW - 1));
  localparam longint HALF  = longint'(1) << (SH - 1);
  localparam longint SAT_P = (MAXV << SH) + HALF;
  localparam logic signed [SW-1:0] MAXS = SW'(MAXV);
  localparam logic signed [SW-1:0] MINS = SW'(MINV);

  logic signed [SW-1:0] sum, shr;
  logic signed [OW-1:0] res;

  assign sum = {p_i[PW-1], p_i} + SW'(HALF);
  assign shr = sum >>> SH;

  always_comb begin
    if (shr > MAXS)      res = OW'(MAXV);
    else if (shr < MINS) res = OW'(MINV);
    else                 res = shr[OW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r_o <= '0;
    else         r_o <= res;
  end

  p_clip_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'(p_i) >= SAT_P) |=> (r_o == OW'(MAXV)));
  p_sign_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_i >= 0) |=> (r_o >= 0));
endmodule

// File: rtl/iq_downmix.sv
module iq_downmix
  import iq_downmix_pkg::*;
#(
  parameter int unsigned SW = SAMPLE_W,
  parameter int unsigned OW = OUT_W,
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned SH = ROUND_SH,
  parameter logic [PW-1:0] INIT_INC = DEF_INC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [SW-1:0] sample_i,
  input  logic                 inc_we_i,
  input  logic [PW-1:0]        inc_i,
  output logic                 valid_o,
  output logic signed [OW-1:0] i_o,
  output logic signed [OW-1:0] q_o
);
  localparam int unsigned MW = 2 * SW;

  logic [IW-1:0]        idx;
  logic signed [SW-1:0] sin_v, cos_v, x_d1;
  logic signed [MW-1:0] prod_i_q, prod_q_q;
  logic                 v_d1, v_d2;
  logic [1:0]           lag_q;

  nco_phase #(.PW(PW), .IW(IW), .INIT_INC(INIT_INC)) u_phase (
    .clk_i, .rst_ni, .we_i(inc_we_i), .inc_i, .idx_o(idx)
  );

  nco_sincos #(.IW(IW), .DW(SW)) u_lut (
    .clk_i, .rst_ni, .idx_i(idx), .sin_o(sin_v), .cos_o(cos_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_d1     <= '0;
      v_d1     <= 1'b0;
      prod_i_q <= '0;
      prod_q_q <= '0;
      v_d2     <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      x_d1     <= sample_i;
      v_d1     <= valid_i;
      prod_i_q <= x_d1 * cos_v;
      prod_q_q <= x_d1 * sin_v;
      v_d2     <= v_d1;
      valid_o  <= v_d2;
    end
  end

  mix_round #(.PW(MW), .OW(OW), .SH(SH)) u_rnd_i (
    .clk_i, .rst_ni, .p_i(prod_i_q), .r_o(i_o)
  );
  mix_round #(.PW(MW), .OW(OW), .SH(SH)) u_rnd_q (
    .clk_i, .rst_ni, .p_i(prod_q_q), .r_o(q_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            lag_q <= '0;
    else if (lag_q != 2'd3) lag_q <= lag_q + 2'd1;
  end

  p_valid_lag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lag_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));
endmodule

// File: tb/iq_downmix_test.sv
module iq_downmix_test;
  localparam logic [31:0] DEF = 32'd919123001;
  localparam real PI = 3.14159265358979323846;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [13:0] sample_i = '0;
  logic inc_we_i = 1'b0;
  logic [31:0] inc_i = '0;
  logic valid_o;
  logic signed [15:0] i_o, q_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  iq_downmix uut (
    .clk_i, .rst_ni, .valid_i, .sample_i, .inc_we_i, .inc_i,
    .valid_o, .i_o, .q_o
  );

  function automatic int e_sin(int p);
    real v = 8191.0 * $sin(2.0 * PI * (real'(p) + 0.5) / 1024.0);
    if (v >= 0.0) return int'($floor(v + 0.5));
    return -int'($floor(-v + 0.5));
  endfunction

  function automatic int e_mix(int x, int c);
    real r = $floor(real'(x * c) / 1024.0 + 0.5);
    if (r > 32767.0) return 32767;
    if (r < -32768.0) return -32768;
    return int'(r);
  endfunction

  // reference model
  logic [31:0] ph_m, inc_m;
  int n_edge;
  int rv [8];
  int ri [8];
  int rq [8];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_m = '0;
      inc_m = DEF;
      n_edge = 0;
      for (int k = 0; k < 8; k++) begin
        rv[k] = 0; ri[k] = 0; rq[k] = 0;
      end
    end else begin
      int p;
      p = int'(ph_m[31:22]);
      rv[n_edge & 7] = int'(valid_i);
      ri[n_edge & 7] = e_mix(int'(sample_i), e_sin((p + 256) % 1024));
      rq[n_edge & 7] = e_mix(int'(sample_i), e_sin(p));
      ph_m = ph_m + inc_m;
      if (inc_we_i) inc_m = inc_i;
      n_edge++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  // call just after a negedge: compare against the model
  task automatic check_out(string tag);
    int ev, k;
    ev = 0;
    k = (n_edge - 3) & 7;
    if (n_edge >= 3) ev = rv[k];
    chk({"R7 valid ", tag}, int'(valid_o), ev);
    if (ev != 0) begin
      chk({"R4 I ", tag}, int'(i_o), ri[k]);
      chk({"R4 Q ", tag}, int'(q_o), rq[k]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    inc_we_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 valid_o in reset", int'(valid_o), 0);
    chk("R1 i_o in reset", int'(i_o), 0);
    chk("R1 q_o in reset", int'(q_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic test_tone(string tag, int x, int cycles);
    for (int c = 0; c < cycles; c++) begin
      sample_i = 14'(x);
      valid_i = 1'b1;
      @(negedge clk_i);
      check_out(tag);
    end
  endtask

  task automatic test_first_phase();
    // R1: first sample after reset sits at phase index 0
    do_reset();
    sample_i = 14'sd4000;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 first I at phase 0", int'(i_o), e_mix(4000, e_sin(256)));
    chk("R1 first Q at phase 0", int'(q_o), e_mix(4000, e_sin(0)));
    chk("R1 first valid", int'(valid_o), 1);
  endtask

  task automatic test_pattern();
    for (int c = 0; c < 300; c++) begin
      sample_i = 14'((c * 1237) % 16384 - 8192);
      valid_i = 1'b1;
      @(negedge clk_i);
      check_out("R5 pattern");
    end
  endtask

  task automatic test_gaps();
    // R9: oscillator keeps moving while valid_i is low
    for (int c = 0; c < 120; c++) begin
      sample_i = 14'sd3000;
      valid_i = ((c % 3) != 0);
      @(negedge clk_i);
      check_out("R9 gaps");
    end
  endtask

  task automatic test_inc_write();
    // R8: load takes effect on the step after the write edge
    sample_i = 14'sd5000;
    valid_i = 1'b1;
    inc_i = 32'h4000_0000;
    inc_we_i = 1'b1;
    @(negedge clk_i);
    check_out("R8 write");
    inc_we_i = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk_i);
      check_out("R8 quarter step");
    end
    inc_i = 32'h0;
    inc_we_i = 1'b1;
    @(negedge clk_i);
    inc_we_i = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk_i);
      check_out("R8 zero step");
    end
    // R2: wrap with a near-full-turn word
    inc_i = 32'hFFC0_0001;
    inc_we_i = 1'b1;
    @(negedge clk_i);
    inc_we_i = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk_i);
      check_out("R2 wrap");
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    test_tone("R2 R3 default tone", 2000, 200);
    test_tone("R6 saturate high", 8191, 100);
    test_tone("R6 saturate low", -8192, 100);
    test_pattern();
    test_gaps();
    test_inc_write();
    test_first_phase();
    test_tone("R1 after mid-run reset", -3500, 60);
    valid_i = 1'b0;
    repeat (4) begin
      @(negedge clk_i);
      check_out("R7 drain");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule